// File: doc/BRIEF.md
# Leading Zero Counter with Grouped Lookahead Merge

This block is combinational. It takes a data word and returns two things: how many zero bits come before the most significant set bit, counting from the MSB, and a flag that is high when no bit of the word is set. A typical use is the exponent adjustment step of a floating-point normaliser, or any place that needs the position of the highest set bit of a word.

The word is split into equal groups of adjacent bits. Every group works on its own bits only. It produces a short local count of its leading zeros and a flag that says whether it holds any set bit. A merge stage then ranks the groups from the top. A group is selected when it is flagged and no group above it is flagged, which is the same prefix structure that forms group signals in a carry-lookahead adder. The result is the rank of the selected group followed by that group's local count. No output is driven by one wide priority gate that spans the whole word. The default build is a 16-bit word in four groups of four bits.

Top module: `lead_zero_count`

## Requirements
- R1: For any non-zero input, `lz_count_o` equals the number of zero bits above the most significant set bit of `word_i`.
- R2: `all_zero_o` is 1 exactly when every bit of `word_i` is 0.
- R3: When `word_i` is all zeros, `lz_count_o` is 0.
- R4: When only bit k of `word_i` is set, `lz_count_o` equals WIDTH-1-k, for every k.
- R5: The upper log2(WIDTH/GROUP) bits of `lz_count_o` give the rank, counted from the top, of the highest group that holds a set bit. The lower log2(GROUP) bits give the leading-zero count inside that group.
- R6: Bits below the most significant set bit have no effect on `lz_count_o` or on `all_zero_o`.
- R7: When all bits of `word_i` are 1, `lz_count_o` is 0 and `all_zero_o` is 0.
- R8: The outputs depend only on the current `word_i`. Applying the same word again gives the same result, whatever words were applied in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_i | input | WIDTH | Word to examine, with bit WIDTH-1 as the MSB |
| lz_count_o | output | log2(WIDTH) | Leading-zero count |
| all_zero_o | output | 1 | High when the word has no set bit |

## Verification
The bench builds the block with its defaults: WIDTH of 16 and GROUP of 4, so there are four groups and a 4-bit count. At this size the bench can apply every single-bit word. That covers every group rank paired with every local count, so both halves of the count field take all of their values. It also applies a set of fixed words in which one group is full and the others are empty. Random words with a forced top bit and random lower bits show that lower bits have no effect on the result. A repeated sweep shows that the output does not depend on the history of inputs.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
    // Default word width and group size shared by the block and its bench
    localparam int unsigned LZC_WIDTH = 16;
    localparam int unsigned LZC_GROUP = 4;
endpackage

// File: rtl/lzc_group.sv
// Per-group leading-zero count and occupancy flag
module lzc_group #(
    parameter int unsigned GROUP = 4,
    localparam int unsigned GW   = $clog2(GROUP)
) (
    input  logic [GROUP-1:0] bits_i,
    output logic [GW-1:0]    pos_o,
    output logic             valid_o
);
    logic [GW-1:0] pos_d;
    logic          valid_d;

    always_comb begin
        pos_d   = '0;
        valid_d = 1'b0;
        // scan upward so the highest set bit wins
        for (int i = 0; i < int'(GROUP); i++) begin
            if (bits_i[i]) begin
                pos_d   = GW'(int'(GROUP) - 1 - i);
                valid_d = 1'b1;
            end
        end
    end

    assign pos_o   = pos_d;
    assign valid_o = valid_d;

    always_comb begin
        if (valid_o) begin
            // R5
            grp_hit_bit_chk: assert (bits_i[int'(GROUP) - 1 - int'(pos_o)] == 1'b1);
        end
        if (!valid_o) begin
            // R3
            grp_idle_pos_chk: assert (pos_o == '0 && bits_i == '0);
        end
    end
endmodule

// File: rtl/lzc_merge.sv
// Lookahead merge: prefix "any group above" chain, one-hot select, OR-combine
module lzc_merge #(
    parameter int unsigned NGRP = 4,
    parameter int unsigned GW   = 2,
    localparam int unsigned IW  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic [NGRP-1:0]    grp_valid_i,  // index 0 is the top group
    input  logic [NGRP*GW-1:0] grp_pos_i,    // rank t at [t*GW +: GW]
    output logic [IW-1:0]      idx_o,
    output logic [GW-1:0]      local_o,
    output logic               none_o
);
    logic [NGRP-1:0] above_d;
    logic [NGRP-1:0] sel_d;
    logic [IW-1:0]   idx_d;
    logic [GW-1:0]   local_d;

    always_comb begin
        above_d[0] = 1'b0;
        for (int t = 1; t < int'(NGRP); t++) begin
            above_d[t] = above_d[t-1] | grp_valid_i[t-1];
        end
        sel_d   = grp_valid_i & ~above_d;
        idx_d   = '0;
        local_d = '0;
        for (int t = 0; t < int'(NGRP); t++) begin
            idx_d   = idx_d   | (sel_d[t] ? IW'(t) : IW'(0));
            local_d = local_d | (sel_d[t] ? grp_pos_i[t*GW +: GW] : GW'(0));
        end
    end

    assign idx_o   = idx_d;
    assign local_o = local_d;
    assign none_o  = ~(above_d[NGRP-1] | grp_valid_i[NGRP-1]);

    always_comb begin
        // R5
        sel_onehot_chk: assert ($onehot0(sel_d));
        // R2
        none_vs_valid_chk: assert (none_o == (grp_valid_i == '0));
    end
endmodule

// File: rtl/lead_zero_count.sv
module lead_zero_count
    import lzc_pkg::*;
#(
    parameter int unsigned WIDTH = LZC_WIDTH,
    parameter int unsigned GROUP = LZC_GROUP,
    localparam int unsigned NGRP = WIDTH / GROUP,
    localparam int unsigned GW   = $clog2(GROUP),
    localparam int unsigned IW   = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int unsigned CW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] word_i,
    output logic [CW-1:0]    lz_count_o,
    output logic             all_zero_o
);
    logic [NGRP-1:0]    grp_valid;
    logic [NGRP*GW-1:0] grp_pos;
    logic [IW-1:0]      idx;
    logic [GW-1:0]      local_lz;
    logic               none;

    for (genvar t = 0; t < NGRP; t++) begin : g_grp
        lzc_group #(.GROUP(GROUP)) u_grp (
            .bits_i  (word_i[WIDTH-1-t*GROUP -: GROUP]),
            .pos_o   (grp_pos[t*GW +: GW]),
            .valid_o (grp_valid[t])
        );
    end

    lzc_merge #(.NGRP(NGRP), .GW(GW)) u_merge (
        .grp_valid_i (grp_valid),
        .grp_pos_i   (grp_pos),
        .idx_o       (idx),
        .local_o     (local_lz),
        .none_o      (none)
    );

    assign lz_count_o = CW'({idx, local_lz});
    assign all_zero_o = none;

    always_comb begin
        // R2
        zero_flag_chk: assert (all_zero_o == (word_i == '0));
        if (word_i == '0) begin
            // R3
            zero_count_chk: assert (lz_count_o == '0);
        end else begin
            // R1
            lead_bit_set_chk: assert (word_i[WIDTH-1-int'(lz_count_o)] == 1'b1);
            // R1
            no_bit_above_chk: assert (lz_count_o == '0 ||
                (word_i >> (WIDTH - int'(lz_count_o))) == '0);
        end
    end
endmodule

// File: tb/lead_zero_count_test.sv
module lead_zero_count_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  word;
    logic [CW-1:0] lz;
    logic          zf;
    int            n_run = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lead_zero_count uut (.word_i(word), .lz_count_o(lz), .all_zero_o(zf));

    function automatic int ref_lz(logic [W-1:0] v);
        int n = 0;
        for (int i = W - 1; i >= 0; i--) begin
            if (v[i]) return n;
            n++;
        end
        return 0;
    endfunction

    task automatic check(string req, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (word %h)", req, got, exp, word);
        end
    endtask

    // drive after the rising edge, sample at the falling edge
    task automatic apply(logic [W-1:0] v);
        @(posedge clk);
        #1 word = v;
        @(negedge clk);
    endtask

    task automatic full_check(logic [W-1:0] v, string req);
        apply(v);
        check({req, " zero flag"}, int'(zf), int'(v == '0));
        check({req, " count"}, int'(lz), ref_lz(v));
    endtask

    initial begin
        word = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R3 R2: all-zero word right after reset
        apply('0);
        check("R2", int'(zf), 1);
        check("R3", int'(lz), 0);

        // R7: all ones
        apply('1);
        check("R7 count", int'(lz), 0);
        check("R7 flag", int'(zf), 0);

        // R4 R5: every single set bit; rank and local halves of the count
        for (int k = 0; k < W; k++) begin
            apply(W'(1) << k);
            check("R4", int'(lz), W - 1 - k);
            check("R5 rank", int'(lz[CW-1:2]), (W - 1 - k) / 4);
            check("R5 local", int'(lz[1:0]), (W - 1 - k) % 4);
            check("R2 single", int'(zf), 0);
        end

        // R5: one group fully populated, others empty
        for (int g = 0; g < 4; g++) begin
            apply(W'(16'hF000) >> (4 * g));
            check("R5 full group", int'(lz), 4 * g);
        end

        // R6: forced top bit, random lower bits
        for (int k = 0; k < W; k++) begin
            for (int r = 0; r < 8; r++) begin
                logic [W-1:0] v;
                v = (W'(1) << k) | (W'($urandom) & ((W'(1) << k) - W'(1)));
                apply(v);
                check("R6 count", int'(lz), W - 1 - k);
                check("R6 flag", int'(zf), 0);
            end
        end

        // R1: random words against the behavioural count
        for (int r = 0; r < 300; r++) begin
            logic [W-1:0] v;
            v = W'($urandom) >> ($urandom % W);
            full_check(v, "R1");
        end

        // R8: same words again after unrelated inputs
        for (int k = 0; k < W; k++) begin
            apply('1);
            apply(W'(1) << k);
            check("R8", int'(lz), W - 1 - k);
        end
        apply(16'h0001);
        apply('0);
        check("R8 zero count", int'(lz), 0);
        check("R8 zero flag", int'(zf), 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule